// File: doc/BRIEF.md
# Processor Bus Address-Phase Receiver

This block receives the address phase of a split-transaction processor bus. The address and request pins are source-synchronous. Two strobes clock them in, one for the low address half together with the request field and one for the high address half. Each strobe captures on both of its edges. The falling edge of a strobe pulse carries the physical address and the request code. The rising edge carries the transaction-type information, which reuses the same pins. All bus pins are active low, and the receiver inverts them into active-high values.

The captured halves cross into the bus-clock domain through toggle synchronisers. A transaction is opened when the active-low address strobe is seen low on a bus clock edge. The record is issued with a one-cycle valid pulse once both strobe groups have completed both of their edges. The optional bit-20 mask clears physical address bit 20 of the issued record. While reset is held, the address pins are sampled as configuration straps, and the straps then stay frozen. A second address strobe that arrives while a transaction is still open is dropped and sets a sticky overflow flag.

Top module: `fsb_addr_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rec_valid` and `overflow` are 0.
- R2: `rec_addr` bits 16..3 are the inverted `a_n` pins at the falling edge of `stb0_n`, and bits 35..17 are the inverted pins at the falling edge of `stb1_n`.
- R3: `rec_req_a` is the inverted `req_n` at the falling edge of `stb0_n`, and `rec_req_b` is the inverted `req_n` at the rising edge of `stb0_n`.
- R4: `rec_ext` bits 16..3 are the inverted `a_n` at the rising edge of `stb0_n`, and bits 35..17 are the inverted `a_n` at the rising edge of `stb1_n`.
- R5: After `ads_n` is sampled low and both strobe groups have completed a full pulse, `rec_valid` is high for exactly one bclk cycle, once per transaction. It is issued one bclk after the last synchronised completion is seen.
- R6: When `a20m_n` is low at the issuing bclk edge, `rec_addr[20]` is 0. When it is high, bit 20 passes unchanged. No other bit is affected.
- R7: `strap` equals the inverted `a_n` at the last rising bclk edge with `rst_n` low, and it does not change while `rst_n` stays high.
- R8: An `ads_n` low sample while a transaction is open sets `overflow`, which stays 1 until reset. The dropped strobe creates no record, and the open transaction's record is delivered unchanged.
- R9: The two strobe groups may complete in either order, and the record is the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous to capture logic |
| ads_n | input | 1 | Active-low new-transaction strobe, bclk domain |
| a20m_n | input | 1 | Active-low address bit 20 mask |
| stb0_n | input | 1 | Strobe for request field and address bits 16..3 |
| stb1_n | input | 1 | Strobe for address bits 35..17 |
| a_n | input | 33 | Active-low address pins, bits 35..3 |
| req_n | input | 5 | Active-low request pins |
| rec_valid | output | 1 | One-cycle record valid pulse |
| rec_addr | output | 33 | Physical address bits 35..3 |
| rec_req_a | output | 5 | Request code from the first sub-phase |
| rec_req_b | output | 5 | Request code from the second sub-phase |
| rec_ext | output | 33 | Transaction-type information from the second sub-phase |
| strap | output | 33 | Straps sampled during reset |
| overflow | output | 1 | Sticky dropped-transaction flag |

## Verification
Random transactions use different values in the two sub-phases on every pin. A swap of the sub-phases, of the strobe groups or of the request halves therefore shows up in the record. The mask is randomised, with address bit 20 forced high in directed cases, so that a missing or misplaced mask is seen. In one directed case the low-half strobe finishes many cycles after the high half, which separates waiting for both groups from issuing on the first. A repeated address strobe with no strobe traffic checks that the flag is sticky, that exactly one record follows and that its content is intact. Changing the pins after reset checks that the straps stay frozen.

// File: rtl/fsb_rx_pkg.sv
package fsb_rx_pkg;
  localparam int ADDR_HI = 35;
  localparam int ADDR_LO = 3;
  localparam int SPLIT   = 17;
  localparam int REQ_W   = 5;
  localparam int MASK_BIT = 20;
  localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;
  localparam int LO_W    = SPLIT - ADDR_LO;
  localparam int HI_W    = ADDR_HI - SPLIT + 1;
  localparam int G0_W    = REQ_W + LO_W;

  function automatic logic [ADDR_W-1:0] apply_mask(input logic [ADDR_W-1:0] a, input logic en);
    logic [ADDR_W-1:0] r;
    r = a;
    if (en) r[MASK_BIT-ADDR_LO] = 1'b0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] join_halves(input logic [HI_W-1:0] hi, input logic [LO_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/fsb_stb_capture.sv
module fsb_stb_capture #(
  parameter int W = 19
) (
  input  logic         rst_n,
  input  logic         stb_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] sub1,
  output logic [W-1:0] sub2,
  output logic         done_tgl
);
  // first edge of an active-low strobe pulse is the falling one
  always_ff @(negedge stb_n or negedge rst_n) begin
    if (!rst_n) sub1 <= '0;
    else        sub1 <= ~d_n;
  end

  // second edge closes the pulse and flags completion to the bus clock
  always_ff @(posedge stb_n or negedge rst_n) begin
    if (!rst_n) begin
      sub2     <= '0;
      done_tgl <= 1'b0;
    end else begin
      sub2     <= ~d_n;
      done_tgl <= ~done_tgl;
    end
  end
endmodule

// File: rtl/fsb_tgl_sync.sv
module fsb_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], tgl_in};
  end

  assign pulse = sh[STAGES] ^ sh[STAGES-1];

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse)
    else $error("toggle sync pulse lasted two cycles");
endmodule

// File: rtl/fsb_addr_rx.sv
module fsb_addr_rx
  import fsb_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 ads_n,
  input  logic                 a20m_n,
  input  logic                 stb0_n,
  input  logic                 stb1_n,
  input  logic [ADDR_HI:ADDR_LO] a_n,
  input  logic [REQ_W-1:0]     req_n,
  output logic                 rec_valid,
  output logic [ADDR_HI:ADDR_LO] rec_addr,
  output logic [REQ_W-1:0]     rec_req_a,
  output logic [REQ_W-1:0]     rec_req_b,
  output logic [ADDR_HI:ADDR_LO] rec_ext,
  output logic [ADDR_HI:ADDR_LO] strap,
  output logic                 overflow
);
  logic [G0_W-1:0] g0_s1, g0_s2;
  logic [HI_W-1:0] g1_s1, g1_s2;
  logic            g0_tgl, g1_tgl;
  logic            g0_done, g1_done;
  logic            pend0, pend1, armed;
  logic            ads_seen, issue_w, drop_w;

  fsb_stb_capture #(.W(G0_W)) u_grp0 (
    .rst_n(rst_n), .stb_n(stb0_n), .d_n({req_n, a_n[SPLIT-1:ADDR_LO]}),
    .sub1(g0_s1), .sub2(g0_s2), .done_tgl(g0_tgl));

  fsb_stb_capture #(.W(HI_W)) u_grp1 (
    .rst_n(rst_n), .stb_n(stb1_n), .d_n(a_n[ADDR_HI:SPLIT]),
    .sub1(g1_s1), .sub2(g1_s2), .done_tgl(g1_tgl));

  fsb_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync0 (
    .clk(bclk), .rst_n(rst_n), .tgl_in(g0_tgl), .pulse(g0_done));
  fsb_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync1 (
    .clk(bclk), .rst_n(rst_n), .tgl_in(g1_tgl), .pulse(g1_done));

  assign ads_seen = !ads_n;
  assign issue_w  = armed && pend0 && pend1;
  assign drop_w   = ads_seen && armed;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pend0 <= 1'b0;
      pend1 <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (issue_w) begin
        armed <= 1'b0;
        pend0 <= 1'b0;
        pend1 <= 1'b0;
      end else begin
        if (ads_seen) armed <= 1'b1;
        if (g0_done)  pend0 <= 1'b1;
        if (g1_done)  pend1 <= 1'b1;
      end
      if (drop_w) overflow <= 1'b1;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      rec_req_a <= '0;
      rec_req_b <= '0;
      rec_ext   <= '0;
    end else begin
      rec_valid <= issue_w;
      if (issue_w) begin
        rec_addr  <= apply_mask(join_halves(g1_s1, g0_s1[LO_W-1:0]), !a20m_n);
        rec_ext   <= join_halves(g1_s2, g0_s2[LO_W-1:0]);
        rec_req_a <= g0_s1[G0_W-1:LO_W];
        rec_req_b <= g0_s2[G0_W-1:LO_W];
      end
    end
  end

  // straps follow the pins through reset and freeze at its release
  always_ff @(posedge bclk) begin
    if (!rst_n) strap <= ~a_n;
  end

  a_r5_valid_after_issue: assert property (@(posedge bclk) disable iff (!rst_n)
    rec_valid |-> $past(armed && pend0 && pend1))
    else $error("record issued without both groups");
  a_r5_one_cycle: assert property (@(posedge bclk) disable iff (!rst_n)
    rec_valid |=> !rec_valid)
    else $error("valid pulse longer than one cycle");
  a_r6_mask_bit: assert property (@(posedge bclk) disable iff (!rst_n)
    rec_valid && !$past(a20m_n) |-> !rec_addr[MASK_BIT])
    else $error("masked bit 20 set");
  a_r7_strap_hold: assert property (@(posedge bclk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap))
    else $error("strap changed after reset");
  a_r8_overflow_sticky: assert property (@(posedge bclk) disable iff (!rst_n)
    $past(overflow) |-> overflow)
    else $error("overflow cleared");
  a_r8_overflow_cause: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(overflow) |-> $past(!ads_n && armed))
    else $error("overflow without repeated strobe");
endmodule

// File: tb/fsb_addr_rx_bench.sv
module fsb_addr_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1, a20m_n = 1'b1, stb0_n = 1'b1, stb1_n = 1'b1;
  logic [35:3] a_n = '1;
  logic [4:0]  req_n = '1;
  logic        rec_valid, overflow;
  logic [35:3] rec_addr, rec_ext, strap;
  logic [4:0]  rec_req_a, rec_req_b;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) bclk = ~bclk;

  fsb_addr_rx u_fsb_addr_rx (
    .bclk(bclk), .rst_n(rst_n), .ads_n(ads_n), .a20m_n(a20m_n),
    .stb0_n(stb0_n), .stb1_n(stb1_n), .a_n(a_n), .req_n(req_n),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_req_a(rec_req_a),
    .rec_req_b(rec_req_b), .rec_ext(rec_ext), .strap(strap), .overflow(overflow));

  function automatic logic [35:3] exp_addr(input logic [35:3] a, input logic mask);
    logic [35:3] r;
    r = a;
    if (mask) r[20] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ads_pulse();
    @(negedge bclk); ads_n = 1'b0;
    @(negedge bclk); ads_n = 1'b1;
  endtask

  // drives both sub-phases; late0 delays the closing edge of strobe 0
  task automatic drive_txn(input logic [35:3] a1, input logic [4:0] q1,
                           input logic [35:3] a2, input logic [4:0] q2,
                           input logic mask, input int late0);
    a20m_n = !mask;
    ads_pulse();
    #1; a_n = ~a1; req_n = ~q1;
    #1; stb0_n = 1'b0; stb1_n = 1'b0;
    #1; a_n = ~a2; req_n = ~q2;
    #1; stb1_n = 1'b1;
    if (late0 == 0) begin
      stb0_n = 1'b1;
    end else begin
      repeat (late0) @(negedge bclk);
      #1; stb0_n = 1'b1;
    end
    #1; a_n = '1; req_n = '1;
  endtask

  task automatic expect_record(input string tag, input logic [35:3] a1, input logic [4:0] q1,
                               input logic [35:3] a2, input logic [4:0] q2, input logic mask);
    int n = 0;
    logic [35:3] ga = '0, ge = '0;
    logic [4:0] gqa = '0, gqb = '0;
    for (int i = 0; i < 25; i++) begin
      @(negedge bclk);
      if (rec_valid) begin
        n++; ga = rec_addr; ge = rec_ext; gqa = rec_req_a; gqb = rec_req_b;
      end
    end
    check({tag, " R5 one record"}, 64'(n), 64'd1);
    check({tag, " R2 R6 addr"}, 64'(ga), 64'(exp_addr(a1, mask)));
    check({tag, " R3 req_a"}, 64'(gqa), 64'(q1));
    check({tag, " R3 req_b"}, 64'(gqb), 64'(q2));
    check({tag, " R4 ext"}, 64'(ge), 64'(a2));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:3] sv;
    logic [35:3] r1, r2;
    logic [4:0] q1, q2;
    void'($urandom(32'd4242));
    sv = 33'h1_2345_6789;
    a_n = ~sv;
    repeat (3) @(negedge bclk);
    check("R1 valid in reset", 64'(rec_valid), 64'd0);
    check("R1 overflow in reset", 64'(overflow), 64'd0);
    rst_n = 1'b1;
    #1; a_n = '1;
    @(negedge bclk);
    check("R1 valid after reset", 64'(rec_valid), 64'd0);
    check("R1 overflow after reset", 64'(overflow), 64'd0);
    check("R7 strap sampled", 64'(strap), 64'(sv));
    a_n = '0;
    repeat (3) @(negedge bclk);
    check("R7 strap frozen", 64'(strap), 64'(sv));
    a_n = '1;

    // directed: bit 20 set, mask off then on
    drive_txn(33'h0_0010_0000 >> 3 | 33'h1_0000_0001, 5'h15, 33'h0_ABCD_1234, 5'h0A, 1'b0, 0);
    expect_record("R6 unmasked", 33'h0_0010_0000 >> 3 | 33'h1_0000_0001, 5'h15, 33'h0_ABCD_1234, 5'h0A, 1'b0);
    drive_txn(33'h1_FFFF_FFFF, 5'h1F, 33'h0_0000_0000, 5'h00, 1'b1, 0);
    expect_record("R6 masked", 33'h1_FFFF_FFFF, 5'h1F, 33'h0_0000_0000, 5'h00, 1'b1);

    // R9: low group finishes long after high group
    drive_txn(33'h0_5555_AAAA, 5'h03, 33'h1_AAAA_5555, 5'h1C, 1'b0, 8);
    expect_record("R9 late strobe0", 33'h0_5555_AAAA, 5'h03, 33'h1_AAAA_5555, 5'h1C, 1'b0);

    // R8: repeated address strobe while open
    ads_pulse();
    ads_pulse();
    @(negedge bclk);
    check("R8 overflow set", 64'(overflow), 64'd1);
    r1 = 33'h0_1357_9BDF; r2 = 33'h1_0246_8ACE;
    #1; a_n = ~r1; req_n = ~5'h11;
    #1; stb0_n = 1'b0; stb1_n = 1'b0;
    #1; a_n = ~r2; req_n = ~5'h06;
    #1; stb0_n = 1'b1; stb1_n = 1'b1;
    #1; a_n = '1; req_n = '1;
    expect_record("R8 kept record", r1, 5'h11, r2, 5'h06, 1'b0);
    check("R8 overflow sticky", 64'(overflow), 64'd1);

    // random transactions
    for (int k = 0; k < 24; k++) begin
      logic m;
      r1 = 33'({$urandom, $urandom});
      r2 = 33'({$urandom, $urandom});
      q1 = 5'($urandom); q2 = 5'($urandom);
      m = 1'($urandom);
      drive_txn(r1, q1, r2, q2, m, int'($urandom % 3));
      expect_record("R2 R3 R4 random", r1, q1, r2, q2, m);
    end
    check("R8 overflow still set", 64'(overflow), 64'd1);
    check("R7 strap end", 64'(strap), 64'(sv));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule